// File: doc/BRIEF.md
# Status Word and Exception Sequencer

This block keeps the 32-bit status word of a small register-based core. It also takes the core into and out of exception handlers. The status word holds:

- four condition flags;
- a field of reserved bits;
- the two interrupt masks;
- the instruction-set state bit;
- a 5-bit mode field.

The ALU updates the flags through a dedicated port. Software writes the word through a control port. Control bits change only when the current mode is privileged, and a write that names a mode that does not exist leaves the mode as it was.

Exception requests are arbitrated by fixed priority. The five request types are reset, fast interrupt, normal interrupt, undefined instruction and supervisor call. The winner is entered in a single cycle:

- the program counter plus one instruction is written to the link register of the target mode's bank;
- the old status word is written to that bank's saved-status register;
- the mode switches, the masks are set and the state bit is cleared;
- a redirect pulse carries the vector address to the fetch unit.

A return strobe, given in a mode that has a bank, restores the status word from the saved copy and redirects fetch to the link value. For the two interrupt modes the link value is first moved back by one instruction.

Top module: `stat_exc_ctrl`

## Requirements

**Status word layout.** Flags N,Z,C,V occupy bits 31,30,29,28. Reserved bits are 27:8. The IRQ mask is bit 7, the FIQ mask is bit 6, the state bit T is bit 5, and the mode is bits 4:0.

**Mode encodings.**

| Mode | Encoding |
|---|---|
| user | 10000 |
| fiq | 10001 |
| irq | 10010 |
| supervisor | 10011 |
| undefined | 11011 |
| system | 11111 |

- R1: After reset, `status_o` = {4'h0, RSVD_INIT[27:8], I=1, F=1, T=0, mode=10011}. `redir_o` = 0 and `fetch_addr_o` = 0.
- R2: A control write whose bits 4:0 are not one of the six mode encodings leaves the mode unchanged. The same write still applies its other permitted fields. The mode field never holds an invalid encoding.
- R3: `flag_we` loads `flag_nzcv` into bits 31:28 on the next clock edge, in every mode.
- R4: In a privileged mode (every mode except user), a control write loads the flags (bits 31:28) and bits 7:5, and loads the mode when it is valid. In user mode the same write changes only the flags.
- R5: Bits 27:8 keep their reset value through flag updates, control writes, exception entries and returns.
- R6: An IRQ request is ignored while bit 7 is 1, and an FIQ request is ignored while bit 6 is 1. The two masks act independently.
- R7: On entry, in one clock edge, the block does all of the following:
  - the target bank's link register takes `pc_i` + INSN_BYTES;
  - its saved-status register takes the prior status word;
  - the mode becomes the target mode: reset→10011, FIQ→10001, IRQ→10010, undefined→11011, supervisor call→10011;
  - I is set, F is set for FIQ and reset only (otherwise unchanged), and T is cleared;
  - `redir_o` pulses for one cycle.
- R8: On entry, `fetch_addr_o` is the vector: reset 0x00, undefined 0x04, supervisor call 0x08, IRQ 0x18, FIQ 0x1C.
- R9: Among simultaneous requests the priority is reset > FIQ > IRQ > undefined > supervisor call. An entry takes precedence over a return or a write in the same cycle.
- R10: A return in the FIQ, IRQ, supervisor or undefined mode restores bits 31:28 and 7:0 from the saved copy and pulses `redir_o`. The fetch address is link − INSN_BYTES in the FIQ and IRQ modes, and the link value in the others. In the user and system modes a return is ignored.
- R11: `saved_o` and `link_o` show the current mode's bank. Both are zero in the user and system modes.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flag_we | input | 1 | Load condition flags from ALU |
| flag_nzcv | input | 4 | New flags N,Z,C,V |
| ctl_we | input | 1 | Software write of the status word |
| ctl_wdata | input | 32 | Written status value |
| rst_req | input | 1 | Reset exception request |
| und_req | input | 1 | Undefined-instruction request |
| svc_req | input | 1 | Supervisor-call request |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| pc_i | input | PC_W | Current program counter |
| ret_i | input | 1 | Exception-return strobe |
| fetch_addr_o | output | PC_W | Redirect target for fetch |
| redir_o | output | 1 | One-cycle redirect pulse |
| status_o | output | 32 | Current status word |
| mode_o | output | 5 | Current mode field |
| thumb_o | output | 1 | Instruction-set state bit |
| irq_mask_o | output | 1 | IRQ disabled |
| fiq_mask_o | output | 1 | FIQ disabled |
| saved_o | output | 32 | Saved status of current bank |
| link_o | output | PC_W | Link value of current bank |

## Verification

**Control writes.** Writes are swept over all 32 mode-field values, both from a privileged mode and from user mode. This separates valid from rejected encodings, and privileged from flag-only writes. Every write carries all-ones reserved bits, so any leak into bits 27:8 is caught.

**Exception requests.** All 31 non-empty combinations of the five request lines are applied from the system mode with both masks clear. Each is followed by a return. This tells apart the priority order, the per-type vector, mode and mask setting, the link and saved captures, and the interrupt-only return adjustment.

**Masks and flags.** Masked single interrupts show that each mask blocks only its own request. A sweep of all 16 flag values over the flag port shows that it reaches only bits 31:28.

// File: rtl/stat_exc_pkg.sv
package stat_exc_pkg;

   localparam int FLAG_LO   = 28;
   localparam int RSV_HI    = 27;
   localparam int RSV_LO    = 8;
   localparam int IMASK_BIT = 7;
   localparam int FMASK_BIT = 6;
   localparam int TBIT      = 5;

   localparam logic [4:0] MD_USR = 5'b10000;
   localparam logic [4:0] MD_FIQ = 5'b10001;
   localparam logic [4:0] MD_IRQ = 5'b10010;
   localparam logic [4:0] MD_SVC = 5'b10011;
   localparam logic [4:0] MD_UND = 5'b11011;
   localparam logic [4:0] MD_SYS = 5'b11111;

   localparam logic [7:0] VEC_RST = 8'h00;
   localparam logic [7:0] VEC_UND = 8'h04;
   localparam logic [7:0] VEC_SVC = 8'h08;
   localparam logic [7:0] VEC_IRQ = 8'h18;
   localparam logic [7:0] VEC_FIQ = 8'h1C;

   localparam int NUM_BANKS = 4;
   localparam int BANK_W    = $clog2(NUM_BANKS);

   function automatic logic mode_ok(input logic [4:0] m);
      case (m)
         MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_UND, MD_SYS: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic mode_banked(input logic [4:0] m);
      case (m)
         MD_FIQ, MD_IRQ, MD_SVC, MD_UND: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [BANK_W-1:0] bank_sel(input logic [4:0] m);
      case (m)
         MD_FIQ:  return BANK_W'(0);
         MD_IRQ:  return BANK_W'(1);
         MD_SVC:  return BANK_W'(2);
         MD_UND:  return BANK_W'(3);
         default: return BANK_W'(0);
      endcase
   endfunction

endpackage

// File: rtl/stat_exc_arb.sv
module stat_exc_arb
   import stat_exc_pkg::*;
(
   input  logic       rst_req,
   input  logic       fiq_req,
   input  logic       irq_req,
   input  logic       und_req,
   input  logic       svc_req,
   input  logic       i_mask,
   input  logic       f_mask,
   output logic       take_o,
   output logic [4:0] tgt_mode_o,
   output logic [7:0] vec_o,
   output logic       set_f_o
);

   always_comb begin
      take_o     = 1'b1;
      tgt_mode_o = MD_SVC;
      vec_o      = VEC_RST;
      set_f_o    = 1'b0;
      if (rst_req) begin
         tgt_mode_o = MD_SVC;
         vec_o      = VEC_RST;
         set_f_o    = 1'b1;
      end else if (fiq_req && !f_mask) begin
         tgt_mode_o = MD_FIQ;
         vec_o      = VEC_FIQ;
         set_f_o    = 1'b1;
      end else if (irq_req && !i_mask) begin
         tgt_mode_o = MD_IRQ;
         vec_o      = VEC_IRQ;
      end else if (und_req) begin
         tgt_mode_o = MD_UND;
         vec_o      = VEC_UND;
      end else if (svc_req) begin
         tgt_mode_o = MD_SVC;
         vec_o      = VEC_SVC;
      end else begin
         take_o     = 1'b0;
      end
   end

endmodule

// File: rtl/stat_exc_wr.sv
module stat_exc_wr
   import stat_exc_pkg::*;
(
   input  logic [31:0] cur_i,
   input  logic        flag_we_i,
   input  logic [3:0]  nzcv_i,
   input  logic        ctl_we_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] nxt_o
);

   logic priv;
   logic unused_rsv_bits;

   assign priv            = (cur_i[4:0] != MD_USR);
   assign unused_rsv_bits = ^wdata_i[RSV_HI:RSV_LO];

   always_comb begin
      nxt_o = cur_i;
      if (flag_we_i)
         nxt_o[31:FLAG_LO] = nzcv_i;
      if (ctl_we_i) begin
         nxt_o[31:FLAG_LO] = wdata_i[31:FLAG_LO];
         if (priv) begin
            nxt_o[IMASK_BIT:TBIT] = wdata_i[IMASK_BIT:TBIT];
            if (mode_ok(wdata_i[4:0]))
               nxt_o[4:0] = wdata_i[4:0];
         end
      end
   end

endmodule

// File: rtl/stat_exc_bank.sv
module stat_exc_bank #(
   parameter int          PC_W    = 32,
   parameter logic [31:0] PSW_RST = 32'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap_i,
   input  logic [PC_W-1:0] link_i,
   input  logic [31:0]     psw_i,
   output logic [PC_W-1:0] link_o,
   output logic [31:0]     psw_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_o <= '0;
         psw_o  <= PSW_RST;
      end else if (cap_i) begin
         link_o <= link_i;
         psw_o  <= psw_i;
      end
   end

endmodule

// File: rtl/stat_exc_ctrl.sv
module stat_exc_ctrl
   import stat_exc_pkg::*;
#(
   parameter int          PC_W       = 32,
   parameter int          INSN_BYTES = 4,
   parameter logic [31:0] RSVD_INIT  = 32'h0,
   parameter bit          RET_ADJ_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flag_we,
   input  logic [3:0]      flag_nzcv,
   input  logic            ctl_we,
   input  logic [31:0]     ctl_wdata,
   input  logic            rst_req,
   input  logic            und_req,
   input  logic            svc_req,
   input  logic            irq_req,
   input  logic            fiq_req,
   input  logic [PC_W-1:0] pc_i,
   input  logic            ret_i,
   output logic [PC_W-1:0] fetch_addr_o,
   output logic            redir_o,
   output logic [31:0]     status_o,
   output logic [4:0]      mode_o,
   output logic            thumb_o,
   output logic            irq_mask_o,
   output logic            fiq_mask_o,
   output logic [31:0]     saved_o,
   output logic [PC_W-1:0] link_o
);

   localparam logic [31:0] RST_PSW =
      {4'h0, RSVD_INIT[RSV_HI:RSV_LO], 1'b1, 1'b1, 1'b0, MD_SVC};

   if (PC_W < 8 || PC_W > 64) begin : g_bad_pcw
      $error("stat_exc_ctrl: PC_W must lie in 8..64");
   end
   if (INSN_BYTES != 2 && INSN_BYTES != 4) begin : g_bad_insn
      $error("stat_exc_ctrl: INSN_BYTES must be 2 or 4");
   end

   logic [31:0]       status_q;
   logic [31:0]       wr_psw;
   logic [31:0]       entry_psw;
   logic [31:0]       restored_psw;
   logic              take;
   logic [4:0]        tgt_mode;
   logic [7:0]        vec;
   logic              set_f;
   logic [BANK_W-1:0] tgt_bank;
   logic [BANK_W-1:0] cur_bank;
   logic              cur_banked;
   logic              ret_go;
   logic [PC_W-1:0]   link_cap;
   logic [PC_W-1:0]   cur_link;
   logic [31:0]       cur_saved;
   logic [PC_W-1:0]   ret_tgt;
   logic [PC_W-1:0]   link_arr [NUM_BANKS];
   logic [31:0]       psw_arr  [NUM_BANKS];

   stat_exc_arb arb_i (
      .rst_req    (rst_req),
      .fiq_req    (fiq_req),
      .irq_req    (irq_req),
      .und_req    (und_req),
      .svc_req    (svc_req),
      .i_mask     (status_q[IMASK_BIT]),
      .f_mask     (status_q[FMASK_BIT]),
      .take_o     (take),
      .tgt_mode_o (tgt_mode),
      .vec_o      (vec),
      .set_f_o    (set_f)
   );

   stat_exc_wr wr_i (
      .cur_i     (status_q),
      .flag_we_i (flag_we),
      .nzcv_i    (flag_nzcv),
      .ctl_we_i  (ctl_we),
      .wdata_i   (ctl_wdata),
      .nxt_o     (wr_psw)
   );

   assign tgt_bank   = bank_sel(tgt_mode);
   assign cur_bank   = bank_sel(status_q[4:0]);
   assign cur_banked = mode_banked(status_q[4:0]);
   assign link_cap   = pc_i + PC_W'(INSN_BYTES);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      stat_exc_bank #(
         .PC_W    (PC_W),
         .PSW_RST (RST_PSW)
      ) bank_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .cap_i  (take && (tgt_bank == BANK_W'(b))),
         .link_i (link_cap),
         .psw_i  (status_q),
         .link_o (link_arr[b]),
         .psw_o  (psw_arr[b])
      );
   end

   assign cur_link  = cur_banked ? link_arr[cur_bank] : '0;
   assign cur_saved = cur_banked ? psw_arr[cur_bank]  : '0;
   assign ret_go    = ret_i && cur_banked && !take;

   if (RET_ADJ_EN) begin : g_ret_adj
      assign ret_tgt = (status_q[4:0] == MD_IRQ || status_q[4:0] == MD_FIQ)
                       ? cur_link - PC_W'(INSN_BYTES) : cur_link;
   end else begin : g_ret_plain
      assign ret_tgt = cur_link;
   end

   assign entry_psw = {status_q[31:RSV_LO], 1'b1,
                       set_f | status_q[FMASK_BIT], 1'b0, tgt_mode};
   assign restored_psw = {cur_saved[31:FLAG_LO], status_q[RSV_HI:RSV_LO],
                          cur_saved[IMASK_BIT:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q     <= RST_PSW;
         redir_o      <= 1'b0;
         fetch_addr_o <= '0;
      end else begin
         redir_o <= take | ret_go;
         if (take) begin
            status_q     <= entry_psw;
            fetch_addr_o <= PC_W'(vec);
         end else if (ret_go) begin
            status_q     <= restored_psw;
            fetch_addr_o <= ret_tgt;
         end else begin
            status_q     <= wr_psw;
         end
      end
   end

   assign status_o   = status_q;
   assign mode_o     = status_q[4:0];
   assign thumb_o    = status_q[TBIT];
   assign irq_mask_o = status_q[IMASK_BIT];
   assign fiq_mask_o = status_q[FMASK_BIT];
   assign saved_o    = cur_saved;
   assign link_o     = cur_link;

endmodule

// File: rtl/stat_exc_chk.sv
module stat_exc_chk
   import stat_exc_pkg::*;
#(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ctl_we,
   input logic            rst_req,
   input logic            und_req,
   input logic            svc_req,
   input logic            irq_req,
   input logic            fiq_req,
   input logic            ret_i,
   input logic [31:0]     status_o,
   input logic            redir_o,
   input logic [PC_W-1:0] fetch_addr_o
);

   a_r2_mode_valid: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ok(status_o[4:0]));

   a_r5_rsvd_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(status_o[RSV_HI:RSV_LO]));

   a_r4_user_ctl: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && status_o[4:0] == MD_USR && !rst_req && !und_req && !svc_req
       && !(irq_req && !status_o[IMASK_BIT]) && !(fiq_req && !status_o[FMASK_BIT]))
      |=> status_o[IMASK_BIT:0] == $past(status_o[IMASK_BIT:0]));

   a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && status_o[IMASK_BIT] && !rst_req && !und_req && !svc_req
       && !(fiq_req && !status_o[FMASK_BIT]) && !ret_i) |=> !redir_o);

   a_r7_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (redir_o && status_o[4:0] == MD_SVC && status_o[IMASK_BIT]
                   && status_o[FMASK_BIT] && !status_o[TBIT] && fetch_addr_o == '0));

   a_r9_fiq_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_req && !status_o[FMASK_BIT] && !rst_req)
      |=> (redir_o && status_o[4:0] == MD_FIQ && fetch_addr_o == PC_W'(VEC_FIQ)));

endmodule

bind stat_exc_ctrl stat_exc_chk #(.PC_W(PC_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_we       (ctl_we),
   .rst_req      (rst_req),
   .und_req      (und_req),
   .svc_req      (svc_req),
   .irq_req      (irq_req),
   .fiq_req      (fiq_req),
   .ret_i        (ret_i),
   .status_o     (status_o),
   .redir_o      (redir_o),
   .fetch_addr_o (fetch_addr_o)
);

// File: tb/stat_exc_ctrl_tb_top.sv
`timescale 1ns/1ps
module stat_exc_ctrl_tb_top;

   localparam logic [31:0] RSVD = 32'h05AA5500;
   localparam logic [19:0] RSV20 = RSVD[27:8];
   localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                          SVC = 5'b10011, UND = 5'b11011, SYS = 5'b11111;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flag_we = 1'b0;
   logic [3:0]  flag_nzcv = '0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic        rst_req = 1'b0, und_req = 1'b0, svc_req = 1'b0;
   logic        irq_req = 1'b0, fiq_req = 1'b0;
   logic [31:0] pc_i = '0;
   logic        ret_i = 1'b0;
   logic [31:0] fetch_addr_o;
   logic        redir_o;
   logic [31:0] status_o;
   logic [4:0]  mode_o;
   logic        thumb_o, irq_mask_o, fiq_mask_o;
   logic [31:0] saved_o;
   logic [31:0] link_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   stat_exc_ctrl #(.RSVD_INIT(RSVD)) dut_i (
      .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_nzcv(flag_nzcv),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rst_req(rst_req),
      .und_req(und_req), .svc_req(svc_req), .irq_req(irq_req),
      .fiq_req(fiq_req), .pc_i(pc_i), .ret_i(ret_i),
      .fetch_addr_o(fetch_addr_o), .redir_o(redir_o), .status_o(status_o),
      .mode_o(mode_o), .thumb_o(thumb_o), .irq_mask_o(irq_mask_o),
      .fiq_mask_o(fiq_mask_o), .saved_o(saved_o), .link_o(link_o)
   );

   task automatic check(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] w);
      ctl_wdata = w;
      ctl_we    = 1'b1;
      cyc();
      ctl_we    = 1'b0;
   endtask

   function automatic bit ok_mode(input logic [4:0] m);
      return (m == USR || m == FIQ || m == IRQ || m == SVC || m == UND || m == SYS);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_vec++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [4:0]  mm;
      logic [31:0] pre, expw, pcv, lnk, rtgt;
      logic [4:0]  emode;
      logic [7:0]  evec;
      logic        esf;

      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      check("R1 status", 64'(status_o), 64'({4'h0, RSV20, 3'b110, SVC}));
      check("R1 redir", 64'(redir_o), 64'd0);
      check("R1 fetch", 64'(fetch_addr_o), 64'd0);
      check("R11 reset saved", 64'(saved_o), 64'({4'h0, RSV20, 3'b110, SVC}));

      // R2 R4 R5 privileged control writes over all mode values
      for (int m = 0; m < 32; m++) begin
         mm = 5'(m);
         if (mm != USR) begin
            wr({4'(m), 20'hFFFFF, ~mm[2:0], mm});
            expw = {4'(m), RSV20, ~mm[2:0], ok_mode(mm) ? mm : SVC};
            check("R2_R4_R5 priv write", 64'(status_o), 64'(expw));
            wr({4'h0, 20'h0, 3'b110, SVC});
         end
      end

      // R3 flag port
      for (int f = 0; f < 16; f++) begin
         flag_nzcv = 4'(f);
         flag_we   = 1'b1;
         cyc();
         flag_we   = 1'b0;
         check("R3 flag port", 64'(status_o), 64'({4'(f), RSV20, 3'b110, SVC}));
      end

      // R7 R8 R9 R10 R11 all request combinations from system mode
      for (int c = 0; c < 32; c++) begin
         wr({4'hA, 20'h0, 3'b001, SYS});
         pre = status_o;
         pcv = 32'h1000 + 32'(c) * 16;
         pc_i = pcv;
         rst_req = c[0]; fiq_req = c[1]; irq_req = c[2];
         und_req = c[3]; svc_req = c[4];
         ret_i = 1'b1;
         cyc();
         rst_req = 0; fiq_req = 0; irq_req = 0; und_req = 0; svc_req = 0;
         ret_i = 1'b0;
         if (c == 0) begin
            check("R10 return ignored in system", 64'(redir_o), 64'd0);
            check("R10 status kept", 64'(status_o), 64'(pre));
            check("R11 no bank in system", 64'({saved_o, link_o}), 64'd0);
         end else begin
            if (c[0])      begin emode = SVC; evec = 8'h00; esf = 1; end
            else if (c[1]) begin emode = FIQ; evec = 8'h1C; esf = 1; end
            else if (c[2]) begin emode = IRQ; evec = 8'h18; esf = 0; end
            else if (c[3]) begin emode = UND; evec = 8'h04; esf = 0; end
            else           begin emode = SVC; evec = 8'h08; esf = 0; end
            lnk = pcv + 4;
            check("R9_R8 vector", 64'(fetch_addr_o), 64'(evec));
            check("R7 redir", 64'(redir_o), 64'd1);
            check("R7 entry status", 64'(status_o),
                  64'({pre[31:8], 1'b1, esf | pre[6], 1'b0, emode}));
            check("R7_R11 saved", 64'(saved_o), 64'(pre));
            check("R7_R11 link", 64'(link_o), 64'(lnk));
            ret_i = 1'b1;
            cyc();
            ret_i = 1'b0;
            rtgt = (emode == IRQ || emode == FIQ) ? pcv : lnk;
            check("R10 return status", 64'(status_o), 64'(pre));
            check("R10 return addr", 64'(fetch_addr_o), 64'(rtgt));
            check("R10 return redir", 64'(redir_o), 64'd1);
         end
      end

      // R6 masks act independently
      wr({4'h0, 20'h0, 3'b100, SYS});
      pre = status_o;
      irq_req = 1'b1; cyc(); irq_req = 1'b0;
      check("R6 irq masked redir", 64'(redir_o), 64'd0);
      check("R6 irq masked status", 64'(status_o), 64'(pre));
      wr({4'h0, 20'h0, 3'b010, SYS});
      pre = status_o;
      fiq_req = 1'b1; cyc(); fiq_req = 1'b0;
      check("R6 fiq masked redir", 64'(redir_o), 64'd0);
      check("R6 fiq masked status", 64'(status_o), 64'(pre));
      wr({4'h0, 20'h0, 3'b100, SYS});
      fiq_req = 1'b1; cyc(); fiq_req = 1'b0;
      check("R6 fiq open with irq masked", 64'(mode_o), 64'(FIQ));
      ret_i = 1'b1; cyc(); ret_i = 1'b0;

      // R4 user-mode writes touch flags only
      wr({4'h3, 20'h0, 3'b000, USR});
      check("R4 enter user", 64'(status_o), 64'({4'h3, RSV20, 3'b000, USR}));
      for (int u = 0; u < 32; u++) begin
         wr({4'(u), 20'hFFFFF, 3'b111, 5'(u)});
         check("R4_R5 user write", 64'(status_o),
               64'({4'(u), RSV20, 3'b000, USR}));
      end
      check("R11 no bank in user", 64'({saved_o, link_o}), 64'd0);
      pre = status_o;
      ret_i = 1'b1; cyc(); ret_i = 1'b0;
      check("R10 return ignored in user", 64'(redir_o), 64'd0);
      pc_i = 32'h2000;
      svc_req = 1'b1; cyc(); svc_req = 1'b0;
      check("R7 svc from user", 64'(status_o), 64'({pre[31:8], 3'b100, SVC}));
      check("R8 svc vector", 64'(fetch_addr_o), 64'h08);
      check("R7 svc saved", 64'(saved_o), 64'(pre));
      ret_i = 1'b1; cyc(); ret_i = 1'b0;
      check("R10 back to user", 64'(status_o), 64'(pre));
      check("R10 svc return addr", 64'(fetch_addr_o), 64'h2004);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule